// File: doc/BRIEF.md
# 512-bit Round-Iterated Permutation Engine

This block evaluates either of two 512-bit permutations, selected per run, that are built from byte-oriented rounds in the style of the AES cipher. The 64 input bytes form an 8 by 8 matrix. The engine applies one complete round per clock and runs ten rounds. It is intended as the core of a compression function for a wide-pipe hash. Message padding and chaining-value feedback are left to the surrounding logic.

Each round has four steps, applied in this order:
1. A round-dependent constant is added to one byte. The byte and the constant depend on which permutation is selected.
2. Every byte goes through the AES substitution box.
3. Each row is rotated left by its row number, counted in columns.
4. Each column is multiplied by an 8 by 8 circulant matrix over GF(2^8).

A one-cycle `start` pulse loads the input word and the permutation select. The result is registered and appears on `dout`. `done` pulses on the cycle in which `dout` first shows the result.

Top module: `perm512_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `dout` is all zero.
- R2: A `start` pulse while `busy` is 0 samples `din` and `sel_q` (0 selects P, 1 selects Q), and `busy` is 1 from the next cycle.
- R3: Exactly ten rounds run. `done` is high for one cycle, ten cycles after the start edge. `busy` falls on that same edge.
- R4: In P, round r (with r from 0 to 9) XORs the byte value r into the byte at row 0, column 0, before substitution.
- R5: In Q, round r XORs 0xFF ^ r into the byte at row 7, column 0, before substitution.
- R6: Every byte passes through the AES S-box, for example 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R7: Row k (k from 0 to 7) is rotated left by k columns. The new byte at (k, c) is the old byte at (k, (c+k) mod 8).
- R8: Output byte (r, c) is the GF(2^8) sum over j of coef[(j - r) mod 8] times byte (j, c). The coef list is 02 02 03 04 05 03 05 07, and the reduction polynomial is x^8+x^4+x^3+x+1.
- R9: A `start` pulse while `busy` is 1 has no effect on the run or its result.
- R10: While idle, `dout` holds the last result until the next accepted `start`.
- R11: Byte i of `din` and `dout` (bits 8i+7 down to 8i) is the matrix entry at row i mod 8, column i div 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| sel_q | input | 1 | 0 selects permutation P, 1 selects Q |
| din | input | 512 | State to be permuted |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the result is registered |
| dout | output | 512 | Permutation state / result |

## Verification
The bench aims at the cases where a small slip changes every output byte:
- A single nonzero byte placed off the diagonal exposes a swapped row/column mapping or a wrong rotation amount.
- Separate P and Q runs on an all-zero state show a misplaced constant or an inverted Q constant.
- A start pulse raised mid-run would restart or corrupt the result if the block did not ignore it. The bench also checks that a run does not finish one cycle early or late, which would shift the `done` pulse against the reference.
- A wrong MixBytes coefficient or a wrong reduction polynomial shows up as a `dout` mismatch on every run.

// File: rtl/p512_pkg.sv
package p512_pkg;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int NBYTE = ROWS * COLS;
  localparam int WIDTH = NBYTE * 8;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xt(p);
    end
    return acc;
  endfunction

  // first row of the circulant matrix
  function automatic logic [7:0] coef(input int k);
    case (k)
      0, 1:    return 8'h02;
      2, 5:    return 8'h03;
      3:       return 8'h04;
      4, 6:    return 8'h05;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/p512_sbox.sv
module p512_sbox (
  input  logic [7:0] a,
  output logic [7:0] y
);
  import p512_pkg::*;

  logic [7:0] inv;

  // inverse as a^254 by square-and-multiply (0 maps to 0)
  always_comb begin
    logic [7:0] p;
    logic [7:0] e;
    inv = 8'h01;
    p   = a;
    e   = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) inv = gmul(inv, p);
      p = gmul(p, p);
    end
  end

  always_comb begin
    y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/p512_mixcol.sv
module p512_mixcol (
  input  logic [63:0] col_in,
  output logic [63:0] col_out
);
  import p512_pkg::*;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic [7:0] s;
      s = '0;
      for (int j = 0; j < ROWS; j++)
        s = s ^ gmul(col_in[8*j +: 8], coef((j - r + ROWS) % ROWS));
      col_out[8*r +: 8] = s;
    end
  end
endmodule

// File: rtl/p512_round.sv
module p512_round (
  input  logic [p512_pkg::WIDTH-1:0] st_in,
  input  logic [7:0]                 rnd,
  input  logic                       is_q,
  output logic [p512_pkg::WIDTH-1:0] st_out
);
  import p512_pkg::*;

  localparam int P_IDX = 0;          // row 0, column 0
  localparam int Q_IDX = ROWS - 1;   // row 7, column 0

  logic [WIDTH-1:0] arc, sub, shf;

  always_comb begin
    arc = st_in;
    if (is_q) arc[8*Q_IDX +: 8] = st_in[8*Q_IDX +: 8] ^ (8'hFF ^ rnd);
    else      arc[8*P_IDX +: 8] = st_in[8*P_IDX +: 8] ^ rnd;
  end

  genvar g, r, c;
  generate
    for (g = 0; g < NBYTE; g++) begin : g_sb
      p512_sbox u_sb (.a(arc[8*g +: 8]), .y(sub[8*g +: 8]));
    end
    for (r = 0; r < ROWS; r++) begin : g_row
      for (c = 0; c < COLS; c++) begin : g_col
        assign shf[8*(r + ROWS*c) +: 8] = sub[8*(r + ROWS*((c + r) % COLS)) +: 8];
      end
    end
    for (c = 0; c < COLS; c++) begin : g_mix
      p512_mixcol u_mc (.col_in(shf[64*c +: 64]), .col_out(st_out[64*c +: 64]));
    end
  endgenerate
endmodule

// File: rtl/perm512_engine.sv
module perm512_engine #(
  parameter int N_ROUNDS = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       sel_q,
  input  logic [p512_pkg::WIDTH-1:0] din,
  output logic                       busy,
  output logic                       done,
  output logic [p512_pkg::WIDTH-1:0] dout
);
  import p512_pkg::*;

  localparam int RW = (N_ROUNDS > 1) ? $clog2(N_ROUNDS) : 1;
  localparam logic [RW-1:0] LAST = RW'(N_ROUNDS - 1);

  logic [WIDTH-1:0] state, nxt;
  logic [RW-1:0]    rnd;
  logic             qsel;

  p512_round u_round (
    .st_in (state),
    .rnd   (8'(rnd)),
    .is_q  (qsel),
    .st_out(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
      rnd   <= '0;
      qsel  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        state <= nxt;
        rnd   <= rnd + 1'b1;
        if (rnd == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        state <= din;
        qsel  <= sel_q;
        rnd   <= '0;
        busy  <= 1'b1;
      end
    end
  end

  assign dout = state;
endmodule

// File: rtl/p512_chk.sv
module p512_chk #(
  parameter int N_ROUNDS = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [511:0] dout
);
  logic [15:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)                cyc <= '0;
    else if (start && !busy) cyc <= '0;
    else if (busy)          cyc <= cyc + 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && dout == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && cyc == 16'(N_ROUNDS)));

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cyc < 16'(N_ROUNDS - 1)) |=> busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(dout));
endmodule

bind perm512_engine p512_chk #(.N_ROUNDS(N_ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .dout(dout)
);

// File: tb/perm512_engine_tb_top.sv
`timescale 1ns/1ps
module perm512_engine_tb_top;
  logic         clk = 0;
  logic         rst = 1;
  logic         start = 0;
  logic         sel_q = 0;
  logic [511:0] din = '0;
  logic         busy, done;
  logic [511:0] dout;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  perm512_engine dut_i (.clk(clk), .rst(rst), .start(start), .sel_q(sel_q),
                        .din(din), .busy(busy), .done(done), .dout(dout));

  // ---------------- reference model ----------------
  int sbt[256];
  int ms[64];
  int m_rnd;
  bit m_busy, m_done, m_q;
  int cf[8] = '{2, 2, 3, 4, 5, 3, 5, 7};

  function automatic int fmul(int a, int b);
    int acc = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) acc ^= a;
      a = a << 1;
      if (a & 'h100) a ^= 'h11B;
    end
    return acc & 'hFF;
  endfunction

  function automatic int rl(int v, int n);
    return ((v << n) | (v >> (8 - n))) & 'hFF;
  endfunction

  initial begin
    for (int a = 0; a < 256; a++) begin
      int inv = 0;
      for (int b = 1; b < 256; b++) if (fmul(a, b) == 1) inv = b;
      sbt[a] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 'h63;
    end
  end

  task automatic ref_round(int r, bit q);
    int s[64];
    int t[64];
    if (q) ms[7] ^= ('hFF ^ r);
    else   ms[0] ^= r;
    for (int i = 0; i < 64; i++) s[i] = sbt[ms[i]];
    for (int row = 0; row < 8; row++)
      for (int c = 0; c < 8; c++) t[row + 8*c] = s[row + 8*((c + row) % 8)];
    for (int c = 0; c < 8; c++)
      for (int row = 0; row < 8; row++) begin
        int acc = 0;
        for (int j = 0; j < 8; j++) acc ^= fmul(t[j + 8*c], cf[(j - row + 8) % 8]);
        ms[row + 8*c] = acc;
      end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_rnd = 0; m_q = 0;
      for (int i = 0; i < 64; i++) ms[i] = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        ref_round(m_rnd, m_q);
        if (m_rnd == 9) begin m_busy = 0; m_done = 1; end
        m_rnd++;
      end else if (start) begin
        for (int i = 0; i < 64; i++) ms[i] = int'(din[8*i +: 8]);
        m_q = sel_q; m_rnd = 0; m_busy = 1;
      end
    end
  end

  function automatic logic [511:0] m_word();
    logic [511:0] w;
    for (int i = 0; i < 64; i++) w[8*i +: 8] = 8'(ms[i]);
    return w;
  endfunction

  task automatic chk(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy === m_busy, "R2 busy", 512'(busy), 512'(m_busy));
      chk(done === m_done, "R3 done", 512'(done), 512'(m_done));
      chk(dout === m_word(), cur_tag, dout, m_word());
    end
  end

  // ---------------- stimulus ----------------
  task automatic launch(logic [511:0] d, bit q, int wait_cyc);
    @(posedge clk); #1;
    din = d; sel_q = q; start = 1;
    @(posedge clk); #1;
    start = 0; din = ~d;
    repeat (wait_cyc) @(posedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [511:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(busy === 0 && done === 0 && dout === '0, "R1 reset", dout, '0);
    // R6: reference S-box sanity on two known points
    chk(sbt[0] == 'h63 && sbt['h53] == 'hED, "R6 sbox", 512'(sbt['h53]), 512'('hED));

    cur_tag = "R4 P constant"; launch('0, 0, 12);
    cur_tag = "R5 Q constant"; launch('0, 1, 12);
    v = '0; v[8*9 +: 8] = 8'h01;               // row 1, column 1
    cur_tag = "R7 R11 shift/mapping"; launch(v, 0, 12);
    v = '0; v[8*62 +: 8] = 8'h80;              // row 6, column 7
    cur_tag = "R7 R11 shift/mapping"; launch(v, 1, 12);
    for (int i = 0; i < 64; i++) v[8*i +: 8] = 8'(i * 7 + 3);
    cur_tag = "R8 R6 mix"; launch(v, 1, 12);

    // R9: extra start pulses during a run are ignored
    cur_tag = "R9 ignore start";
    launch({16{32'hA5A5_1234}}, 0, 3);
    #1 start = 1; sel_q = 1; din = '1;
    @(posedge clk); #1 start = 0;
    repeat (4) @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    repeat (6) @(posedge clk);

    // R10: idle hold, then random runs including back-to-back
    cur_tag = "R10 hold";
    repeat (8) @(posedge clk);
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
      cur_tag = "R2 R8 random";
      launch(v, n[0], (n == 2) ? 9 : 12);
    end
    repeat (5) @(posedge clk);
    summary();
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
    summary();
  end
endmodule